// File: doc/BRIEF.md
# Subtract-and-Branch One-Instruction Processor

This block is a small multi-cycle processor whose only operation is "subtract, then branch if the result is less than or equal to zero". Data words and addresses are both 8 bits wide, and the block holds its own 256-byte memory. Apart from the program counter, the only state is what the sequencer needs to carry one step through. Each step takes three operand bytes at the program counter: A, B and C. It replaces M[B] with (M[B] - M[A]) mod 256. If that result is zero or negative in two's complement, the next PC is C. Otherwise the next PC is PC + 3. When the PC reaches 0xFF, the machine stops.

A host fills memory through a valid/ready load port, pulses `start`, and waits for `halted`. A byte is written on every clock edge where `ld_valid` and `ld_ready` are both high. `ld_ready` is high whenever the core is not executing: during reset, while idle, and while halted. `ld_ready` is low from the cycle after an accepted start until the machine halts. While it is low, offered bytes are not written, and the host must keep them until `ld_ready` returns. A separate debug port shows the memory byte at any address at all times, with no clock delay.

Each step uses six cycles with one memory access per cycle, in this order: fetch A, fetch B, fetch C, read M[A], read M[B], then write M[B] and update the PC.

Top module: `olsq_core`

## Requirements
- R1: After reset the PC is 0, `busy` and `halted` are 0, and `ld_ready` is 1.
- R2: A load writes `ld_data` to `ld_addr` on a clock edge with `ld_valid` and `ld_ready` both high. While the core executes, `ld_ready` is 0 and offered bytes leave memory unchanged.
- R3: Each step stores (M[B] - M[A]) mod 256 into M[B], where A, B and C are the bytes at PC, PC+1 and PC+2.
- R4: If the stored result is 0x00, or has bit 7 set, the next PC is C.
- R5: Otherwise the next PC is PC + 3. The PC and the operand fetch addresses PC+1 and PC+2 wrap modulo 256.
- R6: When the next PC is 0xFF, `halted` rises and `busy` falls after that step's write. The machine then makes no further memory writes until reset.
- R7: A `start` while halted (PC 0xFF) executes nothing. The machine stays halted and memory is unchanged.
- R8: A `start` accepted while idle raises `busy` on the next edge. A program of n steps raises `halted` exactly 6n clock edges after the start edge.
- R9: A step with A equal to B stores zero and takes the branch to C.
- R10: `dbg_data` always equals the memory byte at `dbg_addr`, with no clock delay, including the result of the most recent write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin execution at the current PC (sampled while idle or halted) |
| ld_valid | input | 1 | Load byte offered |
| ld_ready | output | 1 | Load byte accepted this edge (core not executing) |
| ld_addr | input | 8 | Load address |
| ld_data | input | 8 | Load byte |
| dbg_addr | input | 8 | Debug read address |
| dbg_data | output | 8 | Memory byte at `dbg_addr` |
| busy | output | 1 | Core is executing a program |
| halted | output | 1 | PC reached 0xFF; stays high until reset |

## Verification
An accepted `start` raises `busy` on that same edge. Each step's memory write lands on the sixth edge after the step begins, so `halted` is due exactly 6n edges after the start edge. The debug byte reflects a write half a cycle later, at the next falling edge. The reference model advances one phase per rising edge. Every output is compared at the following falling edge, which is the first point where each registered result is visible. The directed part waits a precomputed number of edges and then checks that `halted` is low one edge before its due cycle and high on it.

// File: rtl/olsq_pkg.sv
package olsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FA,
    ST_FB,
    ST_FC,
    ST_RA,
    ST_RB,
    ST_WR,
    ST_HALT
  } olsq_state_e;
endpackage

// File: rtl/olsq_mem.sv
module olsq_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
  end

  assign rdata    = store_q[addr];
  assign dbg_data = store_q[dbg_addr];
endmodule

// File: rtl/olsq_alu.sv
module olsq_alu #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] minuend,
  input  logic [DW-1:0] subtrahend,
  output logic [DW-1:0] diff,
  output logic          leq
);
  always_comb begin
    diff = minuend - subtrahend;
    leq  = diff[DW-1] | (diff == '0);
  end
endmodule

// File: rtl/olsq_seq.sv
module olsq_seq
  import olsq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] rdata,
  input  logic          leq_i,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b,
  output logic          busy,
  output logic          halted
);
  localparam logic [AW-1:0] STOP_PC = '1;
  localparam logic [AW-1:0] STRIDE  = AW'(3);

  olsq_state_e   state_q;
  logic [AW-1:0] pc_q, a_ptr_q, b_ptr_q, c_ptr_q;
  logic [DW-1:0] va_q, vb_q;
  logic [AW-1:0] next_pc;

  assign next_pc = leq_i ? c_ptr_q : pc_q + STRIDE;

  always_comb begin
    unique case (state_q)
      ST_FA:   mem_addr = pc_q;
      ST_FB:   mem_addr = pc_q + AW'(1);
      ST_FC:   mem_addr = pc_q + AW'(2);
      ST_RA:   mem_addr = a_ptr_q;
      ST_RB:   mem_addr = b_ptr_q;
      ST_WR:   mem_addr = b_ptr_q;
      default: mem_addr = pc_q;
    endcase
  end

  assign mem_we = (state_q == ST_WR);
  assign opnd_a = va_q;
  assign opnd_b = vb_q;
  assign busy   = (state_q != ST_IDLE) && (state_q != ST_HALT);
  assign halted = (state_q == ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      pc_q    <= '0;
      a_ptr_q <= '0;
      b_ptr_q <= '0;
      c_ptr_q <= '0;
      va_q    <= '0;
      vb_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) state_q <= (pc_q == STOP_PC) ? ST_HALT : ST_FA;
        ST_FA: begin a_ptr_q <= AW'(rdata); state_q <= ST_FB; end
        ST_FB: begin b_ptr_q <= AW'(rdata); state_q <= ST_FC; end
        ST_FC: begin c_ptr_q <= AW'(rdata); state_q <= ST_RA; end
        ST_RA: begin va_q <= rdata; state_q <= ST_RB; end
        ST_RB: begin vb_q <= rdata; state_q <= ST_WR; end
        ST_WR: begin
          pc_q    <= next_pc;
          state_q <= (next_pc == STOP_PC) ? ST_HALT : ST_FA;
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  // R4: a taken branch loads the C operand
  a_r4_branch_to_c: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR && leq_i) |=> (pc_q == $past(c_ptr_q)));

  // R5: fall-through advances by three, modulo 256
  a_r5_step_three: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR && !leq_i) |=> (pc_q == $past(pc_q) + STRIDE));

  // R9: identical operand addresses always branch
  a_r9_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WR && a_ptr_q == b_ptr_q) |-> leq_i);

  // R6: halt is sticky until reset
  a_r6_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

// File: rtl/olsq_core.sv
module olsq_core
  import olsq_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] dbg_addr,
  output logic [DW-1:0] dbg_data,
  output logic          busy,
  output logic          halted
);
  logic [AW-1:0] core_addr, mem_addr;
  logic          core_we, mem_we;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [DW-1:0] opnd_a, opnd_b, diff;
  logic          leq;

  olsq_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .rdata    (mem_rdata),
    .leq_i    (leq),
    .mem_addr (core_addr),
    .mem_we   (core_we),
    .opnd_a   (opnd_a),
    .opnd_b   (opnd_b),
    .busy     (busy),
    .halted   (halted)
  );

  olsq_alu #(.DW(DW)) u_alu (
    .minuend    (opnd_b),
    .subtrahend (opnd_a),
    .diff       (diff),
    .leq        (leq)
  );

  assign ld_ready  = !busy;
  assign mem_addr  = busy ? core_addr : ld_addr;
  assign mem_we    = busy ? core_we : (ld_valid && ld_ready);
  assign mem_wdata = busy ? diff : ld_data;

  olsq_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk      (clk),
    .we       (mem_we),
    .addr     (mem_addr),
    .wdata    (mem_wdata),
    .rdata    (mem_rdata),
    .dbg_addr (dbg_addr),
    .dbg_data (dbg_data)
  );

  // R6: no core write once halted
  a_r6_quiet_halt: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !core_we);

  // R8: an accepted start from idle leaves idle on the next edge
  a_r8_start_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !halted && start) |=> (busy || halted));
endmodule

// File: tb/olsq_core_bench.sv
module olsq_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       ld_valid = 1'b0;
  logic       ld_ready;
  logic [7:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic [7:0] dbg_addr, dbg_data;
  logic       busy, halted;

  logic       scan_en = 1'b1;
  logic [7:0] scan_addr = '0;
  logic [7:0] chk_addr = '0;
  assign dbg_addr = scan_en ? scan_addr : chk_addr;

  int errs = 0;
  int checks = 0;
  bit cmp_en = 0;

  // reference model state
  int m_mem [256];
  int m_pc = 0;
  bit m_run = 0;
  bit m_halt = 0;
  int m_phase = 0;
  int prog [256];

  always #10 clk = ~clk;

  olsq_core u_olsq_core (
    .clk(clk), .rst_n(rst_n), .start(start),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_addr(dbg_addr), .dbg_data(dbg_data), .busy(busy), .halted(halted)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural model, one phase per rising edge
  always @(posedge clk) begin
    if (!m_run && ld_valid) m_mem[ld_addr] = int'(ld_data);
    if (!rst_n) begin
      m_pc = 0; m_run = 0; m_halt = 0; m_phase = 0;
    end else if (m_run) begin
      m_phase++;
      if (m_phase == 6) begin
        int a, b, c, r;
        a = m_mem[m_pc];
        b = m_mem[(m_pc + 1) % 256];
        c = m_mem[(m_pc + 2) % 256];
        r = (m_mem[b] - m_mem[a] + 256) % 256;
        m_mem[b] = r;
        m_pc = (r == 0 || r >= 128) ? c : (m_pc + 3) % 256;
        m_phase = 0;
        if (m_pc == 255) begin m_run = 0; m_halt = 1; end
      end
    end else if (start && !m_halt) begin
      if (m_pc == 255) m_halt = 1;
      else begin m_run = 1; m_phase = 0; end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk(int'(busy), int'(m_run), "R8 busy");
      chk(int'(halted), int'(m_halt), "R6 halted");
      chk(int'(ld_ready), int'(!m_run), "R2 ld_ready");
      if (scan_en) begin
        chk(int'(dbg_data), m_mem[dbg_addr], "R10/R3 dbg_data");
        scan_addr <= scan_addr + 8'd1;
      end
    end
  end

  task automatic do_reset();
    @(posedge clk); #5 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    #5 rst_n = 1'b1; cmp_en = 1;
  endtask

  task automatic load_prog();
    for (int i = 0; i < 256; i++) begin
      @(posedge clk); #5 ld_valid = 1'b1; ld_addr = 8'(i); ld_data = 8'(prog[i]);
    end
    @(posedge clk); #5 ld_valid = 1'b0;
  endtask

  task automatic peek(input int addr, input int exp, input string tag);
    scan_en = 1'b0; chk_addr = 8'(addr);
    #1 chk(int'(dbg_data), exp, tag);
    scan_en = 1'b1;
  endtask

  // start, optionally poke the load port mid-run, check halt timing (R8)
  task automatic go(input int n_steps, input bit poke);
    int rest;
    @(posedge clk); #5 start = 1'b1;
    @(posedge clk); #5 start = 1'b0;
    rest = 6 * n_steps - 1;
    if (poke) begin
      ld_valid = 1'b1; ld_addr = 8'h30; ld_data = 8'hAA;
      chk(int'(ld_ready), 0, "R2 ready low while busy");
      @(posedge clk); #5 ld_valid = 1'b0;
      rest = rest - 1;
    end
    repeat (rest) @(posedge clk);
    #5 chk(int'(halted), 0, "R8 halted not early");
    @(posedge clk); #5 chk(int'(halted), 1, "R8 halted on time");
    chk(int'(busy), 0, "R6 busy low at halt");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 0;
    do_reset();
    #1 chk(int'(busy), 0, "R1 busy");
    chk(int'(halted), 0, "R1 halted");
    chk(int'(ld_ready), 1, "R1 ld_ready");

    // program 1: positive result, equal operands, negative result to halt
    for (int i = 0; i < 256; i++) prog[i] = 0;
    prog[0] = 8'h10; prog[1] = 8'h11; prog[2] = 8'h03;
    prog[3] = 8'h12; prog[4] = 8'h12; prog[5] = 8'h09;
    prog[6] = 8'h10; prog[7] = 8'h14; prog[8] = 8'hFF;
    prog[9] = 8'h10; prog[10] = 8'h13; prog[11] = 8'hFF;
    prog[8'h10] = 3; prog[8'h11] = 5; prog[8'h12] = 7;
    prog[8'h13] = 1; prog[8'h14] = 9;
    load_prog();
    peek(8'h11, 5, "R2 loaded byte");
    go(3, 0);
    peek(8'h11, 2, "R3 5-3 stored");
    peek(8'h12, 0, "R9 self subtract zero");
    peek(8'h14, 9, "R4 skipped step untouched");
    peek(8'h13, 8'hFE, "R3 negative wrap");

    // program 2: wrap of fetch addresses and PC, countdown loop
    do_reset();
    for (int i = 0; i < 256; i++) prog[i] = 0;
    prog[0] = 8'h20; prog[1] = 8'h21; prog[2] = 8'hFD;
    prog[8'hFD] = 8'h22; prog[8'hFE] = 8'h23; prog[8'hFF] = 8'h40;
    prog[8'h40] = 8'h20; prog[8'h41] = 8'h24; prog[8'h42] = 8'hFF;
    prog[8'h20] = 1; prog[8'h21] = 1; prog[8'h22] = 1; prog[8'h23] = 5;
    load_prog();
    go(11, 1);
    peek(8'h21, 8'hFC, "R5 loop count");
    peek(8'h23, 0, "R10 wrapped fetch result");
    peek(8'h24, 8'hFF, "R6 last step");
    peek(8'h30, 0, "R2 busy load ignored");

    // start while halted
    @(posedge clk); #5 start = 1'b1;
    @(posedge clk); #5 start = 1'b0;
    repeat (8) @(posedge clk);
    #5 chk(int'(halted), 1, "R7 stays halted");
    chk(int'(busy), 0, "R7 not busy");
    peek(8'h21, 8'hFC, "R7 memory unchanged");

    // load while halted is accepted
    @(posedge clk); #5 ld_valid = 1'b1; ld_addr = 8'h31; ld_data = 8'h5A;
    @(posedge clk); #5 ld_valid = 1'b0;
    peek(8'h31, 8'h5A, "R2 load when halted");

    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errs++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule